// File: doc/BRIEF.md
# Table-Driven 48-Bit Ones Counter

This block reports how many bits are set in a 48-bit word. The word is cut into four 12-bit slices. Each slice addresses a read-only table whose entry at every address is the number of ones in that address, so each table read returns a 4-bit partial count directly. Two dual-read tables serve the four slices, two slices per table. A registered adder stage then joins the four partial counts: two pair sums feed one final sum, giving a 6-bit total from 0 to 48.

The tables are synchronous, so the block is a fixed two-stage pipeline. The first stage is the table read and the second is the adder register. A word offered with the input strobe high produces its count, with the output flag high, exactly two clock edges later. A new word can be offered on every cycle, and results leave in arrival order. The table contents are computed during elaboration by a loop, so no initialisation file is needed. A synchronous reset empties the valid pipeline. The data path registers are not reset.

Top module: `popc_lut48`

## Requirements
- R1: For every accepted word, `out_count` equals the number of 1 bits in that 48-bit `in_data`.
- R2: `out_valid` is high at the second rising edge after an edge that sampled `in_valid` high, and low at the second edge after one that sampled it low.
- R3: Words offered on consecutive cycles are all counted, and the counts appear on consecutive cycles in the order the words arrived.
- R4: While `rst` is sampled high, `out_valid` is low on the following cycle. Words offered during reset never produce a high `out_valid`.
- R5: The count stays within 0 to 48. An all-zero word yields 0 and an all-ones word yields 48.
- R6: A word with a single 1 bit yields 1, whatever its position from 0 to 47.
- R7: A word whose only set bits fill one complete 12-bit slice (bits 12k to 12k+11, for k from 0 to 3) yields 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a word to be counted this cycle |
| in_data | input | 48 | Word whose set bits are counted |
| out_valid | output | 1 | Marks `out_count` as the result for the word offered two cycles earlier |
| out_count | output | 6 | Number of set bits, 0 to 48 |

## Verification
Two things can happen on the same edge. A fresh word can be captured into the table stage while the previous word's partial counts are added and leave the block. A reset can also arrive while words are still in both stages. The bench drives long unbroken runs of valid words, so capture and output overlap on every edge, and it mixes in strobe gaps and a reset in the middle of a stream. A cycle-accurate model of the two-stage valid pipeline is kept in the bench. Each cycle, the output flag is compared against that model, and every flagged count is compared against an independently computed ones-count of the word that entered two cycles before.

// File: rtl/popc_pkg.sv
package popc_pkg;

    // Number of set bits in the low `width` bits of v (elaboration-time use).
    function automatic int ones_of(input logic [31:0] v, input int width);
        int n;
        n = 0;
        for (int b = 0; b < width; b++) begin
            if (v[b]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/popc_lut_dp.sv
module popc_lut_dp #(
    parameter int GRP_W  = 12,
    parameter int PART_W = $clog2(GRP_W + 1)
) (
    input  logic              clk,
    input  logic [GRP_W-1:0]  addr_a,
    input  logic [GRP_W-1:0]  addr_b,
    output logic [PART_W-1:0] data_a,
    output logic [PART_W-1:0] data_b
);
    localparam int DEPTH = 1 << GRP_W;

    logic [PART_W-1:0] table_q [DEPTH];

    // Entry i holds the number of ones in i; computed, not loaded.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            table_q[i] = PART_W'(popc_pkg::ones_of(32'(i), GRP_W));
        end
    end

    always_ff @(posedge clk) begin
        data_a <= table_q[addr_a];
        data_b <= table_q[addr_b];
    end

    // R6: each read port returns the ones-count of the slice it was given
    assert_port_a_R6: assert property (@(posedge clk)
        ##1 (data_a == PART_W'($countones($past(addr_a)))));
    assert_port_b_R6: assert property (@(posedge clk)
        ##1 (data_b == PART_W'($countones($past(addr_b)))));

endmodule

// File: rtl/popc_sum_tree.sv
module popc_sum_tree #(
    parameter int NGRP   = 4,
    parameter int PART_W = 4,
    parameter int CNT_W  = 6
) (
    input  logic                     clk,
    input  logic [NGRP*PART_W-1:0]   parts,
    output logic [CNT_W-1:0]         sum_q
);
    localparam int NPAIR   = NGRP / 2;
    localparam int MAX_SUM = NGRP * ((1 << PART_W) - 1);

    logic [CNT_W-1:0] pair_sum [NPAIR];
    logic [CNT_W-1:0] total;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_sum[p] = CNT_W'(parts[(2*p)*PART_W +: PART_W])
                           + CNT_W'(parts[(2*p+1)*PART_W +: PART_W]);
    end

    always_comb begin
        total = '0;
        for (int p = 0; p < NPAIR; p++) begin
            total = total + pair_sum[p];
        end
    end

    always_ff @(posedge clk) begin
        sum_q <= total;
    end

    // R5: the registered sum never exceeds what the partial counts allow
    assert_sum_bound_R5: assert property (@(posedge clk)
        ##1 (int'(sum_q) <= MAX_SUM));

endmodule

// File: rtl/popc_lut48.sv
module popc_lut48 #(
    parameter int DATA_W = 48,
    parameter int GRP_W  = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    output logic                        out_valid,
    output logic [$clog2(DATA_W+1)-1:0] out_count
);
    localparam int NGRP   = DATA_W / GRP_W;
    localparam int NMEM   = NGRP / 2;
    localparam int PART_W = $clog2(GRP_W + 1);
    localparam int CNT_W  = $clog2(DATA_W + 1);

    logic [NGRP*PART_W-1:0] parts;
    logic                   valid_rd_q;
    logic                   valid_sum_q;

    // Stage 1: table reads, two slices per dual-read table
    for (genvar m = 0; m < NMEM; m++) begin : g_table
        popc_lut_dp #(
            .GRP_W  (GRP_W),
            .PART_W (PART_W)
        ) u_table (
            .clk    (clk),
            .addr_a (in_data[(2*m)*GRP_W   +: GRP_W]),
            .addr_b (in_data[(2*m+1)*GRP_W +: GRP_W]),
            .data_a (parts[(2*m)*PART_W    +: PART_W]),
            .data_b (parts[(2*m+1)*PART_W  +: PART_W])
        );
    end

    // Stage 2: registered adder tree
    popc_sum_tree #(
        .NGRP   (NGRP),
        .PART_W (PART_W),
        .CNT_W  (CNT_W)
    ) u_sum (
        .clk   (clk),
        .parts (parts),
        .sum_q (out_count)
    );

    // Valid pipeline, the only reset state
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_rd_q  <= 1'b0;
            valid_sum_q <= 1'b0;
        end else begin
            valid_rd_q  <= in_valid;
            valid_sum_q <= valid_rd_q;
        end
    end

    assign out_valid = valid_sum_q;

    // R2: flag follows the strobe by exactly two edges
    assert_latency_hi_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);
    assert_latency_lo_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    // R1: the count belongs to the word two edges back
    assert_count_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 (out_count == CNT_W'($countones($past(in_data, 2)))));

    // R4: reset empties the output flag
    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R5: a flagged count never exceeds the word width
    assert_range_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_count) <= DATA_W));

endmodule

// File: tb/popc_lut48_tb.sv
`timescale 1ns/1ps
module popc_lut48_tb;
    localparam int DATA_W = 48;
    localparam int CNT_W  = 6;
    localparam real HALF  = 4.0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [CNT_W-1:0]  out_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the two-stage pipeline
    bit m_v1 = 0, m_v2 = 0;
    int m_c1 = 0, m_c2 = 0;
    string m_t1 = "", m_t2 = "";

    popc_lut48 #(.DATA_W(DATA_W), .GRP_W(12)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_count(out_count)
    );

    always #(HALF) clk = ~clk;

    function automatic int bits_set(input logic [DATA_W-1:0] w);
        int n = 0;
        for (int i = 0; i < DATA_W; i++) n += int'(w[i]);
        return n;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Drive one cycle, advance the model at the edge, check after it.
    task automatic step(input bit r, input bit v, input logic [DATA_W-1:0] d,
                        input string tag);
        rst = r; in_valid = v; in_data = d;
        @(posedge clk);
        m_v2 = r ? 1'b0 : m_v1; m_c2 = m_c1; m_t2 = m_t1;
        m_v1 = r ? 1'b0 : v;    m_c1 = bits_set(d); m_t1 = tag;
        @(negedge clk);
        checks++;
        if (out_valid !== m_v2) begin
            errors++;
            $display("FAIL %s out_valid actual=%0b expected=%0b",
                     r ? "R4" : "R2", out_valid, m_v2);
        end
        if (m_v2) begin
            checks++;
            if (int'(out_count) !== m_c2) begin
                errors++;
                $display("FAIL %s out_count actual=%0d expected=%0d",
                         m_t2, out_count, m_c2);
            end
        end
    endtask

    initial begin
        #(HALF * 2.0 * 200000.0);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20231));
        @(negedge clk);
        // R4: words offered during reset never come out flagged
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, {DATA_W{1'b1}}, "R4");
        // R5: extremes
        step(1'b0, 1'b1, '0, "R5");
        step(1'b0, 1'b1, {DATA_W{1'b1}}, "R5");
        // R6: every single-bit position, back to back (R3)
        for (int i = 0; i < DATA_W; i++)
            step(1'b0, 1'b1, DATA_W'(1) << i, "R6");
        // R7: each full slice
        for (int k = 0; k < 4; k++)
            step(1'b0, 1'b1, DATA_W'(12'hFFF) << (12 * k), "R7");
        // R2: isolated strobes with gaps
        step(1'b0, 1'b0, {DATA_W{1'b1}}, "R2");
        step(1'b0, 1'b1, 48'h0123_4567_89AB, "R2");
        step(1'b0, 1'b0, '0, "R2");
        step(1'b0, 1'b0, '0, "R2");
        // R1/R3: unbroken random stream
        for (int i = 0; i < 300; i++)
            step(1'b0, 1'b1, DATA_W'({$urandom(), $urandom()}), "R1");
        // R4: reset in mid-stream, words in flight are dropped
        step(1'b1, 1'b1, DATA_W'({$urandom(), $urandom()}), "R4");
        step(1'b0, 1'b1, DATA_W'({$urandom(), $urandom()}), "R4");
        // R1/R2: random strobe pattern
        for (int i = 0; i < 400; i++)
            step(1'b0, ($urandom() % 4) != 0,
                 DATA_W'({$urandom(), $urandom()}), "R1");
        // flush
        step(1'b0, 1'b0, '0, "R2");
        step(1'b0, 1'b0, '0, "R2");
        done = 1;
        summary();
        $finish;
    end
endmodule